// File: doc/BRIEF.md
# Dual-Standard FSK Tone Modulator

This block synthesizes the transmit carrier of a 300-baud frequency-shift-keyed modem as a stream of signed digital sine samples. It runs from a 3.579545 MHz reference clock and divides that clock by 46 to produce a sample strobe at about 77.82 kHz. On each strobe a 24-bit phase accumulator advances by a tuning word, and a folded quarter-wave table turns the top phase bits into a 10-bit two's-complement sample. All output tones scale in proportion to the reference clock.

The tone depends on the chosen signalling standard (Bell 103 or V.21), on whether the station originates or answers the call, and on the transmit bit. An echo-tone request overrides the data with a fixed tone. Squelch silences the output but keeps the strobe running, and power-down stops the strobe and clears the phase. When the tone changes, only the increment changes and the phase carries on, so the waveform has no phase jump.

A four-state controller chooses the behaviour. ST_OFF is entered from any state when power-down is high. ST_MUTE is entered from any state when power-down is low and squelch is high. ST_ECHO is entered when both are low and the echo tone is requested. ST_DATA is entered otherwise. Every transition between any pair of these states follows this priority order, and it is evaluated on every clock.

Top module: `fsk_tone_mod`

## Requirements
- R1: `sample_vld_o` is a single-cycle pulse, and outside power-down it repeats exactly once every 46 clock cycles.
- R2: With `std_v21_i`=0 (Bell 103) and `originate_i`=1, the tone is 1070 Hz for `tx_bit_i`=0 (space) and 1270 Hz for `tx_bit_i`=1 (mark).
- R3: With `std_v21_i`=0 and `originate_i`=0 (answer), the tone is 2025 Hz for space and 2225 Hz for mark.
- R4: With `std_v21_i`=1 (V.21) and `originate_i`=1 (channel 1), the tone is 980 Hz for mark and 1180 Hz for space.
- R5: With `std_v21_i`=1 and `originate_i`=0 (channel 2), the tone is 1650 Hz for mark and 1850 Hz for space.
- R6: With `echo_req_i`=1, the tone is 2100 Hz under V.21 and 2225 Hz under Bell 103, whatever the values of `tx_bit_i` and `originate_i`.
- R7: With `squelch_i`=1, every strobed sample is 0 and the strobe continues. The phase does not advance, and it resumes from its held value when squelch is released.
- R8: Priority is power-down over squelch, and squelch over the echo request.
- R9: With `pwr_down_i`=1, no strobe is produced, the sample is 0 and the phase is cleared. The first sample after release is therefore the sine of one increment.
- R10: A change of tone keeps the phase continuous. Each new increment is added to the phase reached under the previous tone.
- R11: The increment for a tone f is round(f * 2^24 * 46 / 3579545). The sample is a 10-bit two's-complement value with a full scale of ±511, taken from a 64-entry quarter wave indexed by phase bits [21:16], with the quadrant in bits [23:22].
- R12: While reset is low, `sample_o` is 0, `sample_vld_o` is 0 and the phase is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, 3.579545 MHz nominal |
| rst_n | input | 1 | Active-low synchronous reset |
| pwr_down_i | input | 1 | Power-down request |
| squelch_i | input | 1 | Silences the modulator output |
| echo_req_i | input | 1 | Requests the fixed echo tone |
| std_v21_i | input | 1 | 1 selects V.21, 0 selects Bell 103 |
| originate_i | input | 1 | 1 selects originate (channel 1), 0 selects answer (channel 2) |
| tx_bit_i | input | 1 | Transmit data: 1 is mark, 0 is space |
| sample_o | output | 10 | Signed sine sample, held between strobes |
| sample_vld_o | output | 1 | One-cycle strobe marking a new sample |

## Verification
Squelch and the echo request can be active in the same cycle, and so can squelch and power-down. The bench provokes both cases by raising the lines together. For squelch with the echo request, it expects exact zeros with the strobe still running and the phase frozen. For squelch with power-down, it expects no strobe at all, and after release it expects a first sample that starts from phase zero. A reference phase, kept in the bench across every tone change, judges the tone in each case. It also catches any phase jump or any phase advance under squelch.

// File: rtl/fsk_mod_pkg.sv
package fsk_mod_pkg;

    typedef enum logic [1:0] {
        ST_OFF  = 2'd0,
        ST_DATA = 2'd1,
        ST_ECHO = 2'd2,
        ST_MUTE = 2'd3
    } fsk_state_e;

    typedef enum logic [3:0] {
        TN_B103_ORG_SPACE = 4'd0,
        TN_B103_ORG_MARK  = 4'd1,
        TN_B103_ANS_SPACE = 4'd2,
        TN_B103_ANS_MARK  = 4'd3,
        TN_V21_CH1_MARK   = 4'd4,
        TN_V21_CH1_SPACE  = 4'd5,
        TN_V21_CH2_MARK   = 4'd6,
        TN_V21_CH2_SPACE  = 4'd7,
        TN_V21_ECHO       = 4'd8,
        TN_B103_ECHO      = 4'd9
    } tone_e;

    localparam int NUM_TONES = 16;

    // Nominal frequency in Hz for each tone slot; unused slots give 0.
    function automatic int tone_hz(int idx);
        case (idx)
            0:       return 1070;
            1:       return 1270;
            2:       return 2025;
            3:       return 2225;
            4:       return 980;
            5:       return 1180;
            6:       return 1650;
            7:       return 1850;
            8:       return 2100;
            9:       return 2225;
            default: return 0;
        endcase
    endfunction

    // Rounded phase increment per sample for a given tone.
    function automatic longint tuning_word(int hz, int clk_hz, int div, int pw);
        longint num;
        num = longint'(hz) * longint'(div) * (longint'(1) << pw);
        return (num + longint'(clk_hz / 2)) / longint'(clk_hz);
    endfunction

    // Quarter-wave magnitude at the centre of slot i of n, fixed-point Taylor series.
    function automatic int qwave(int i, int n, int amp);
        longint half_pi;
        longint x;
        longint x2;
        longint term;
        longint sum;
        half_pi = 64'sd1686629713;
        x       = (half_pi * longint'(2 * i + 1)) / longint'(2 * n);
        x2      = (x * x) >>> 30;
        term    = x;
        sum     = x;
        for (int k = 1; k <= 8; k++) begin
            term = -(((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1)));
            sum  = sum + term;
        end
        return int'((sum * longint'(amp) + (64'sd1 <<< 29)) >>> 30);
    endfunction

endpackage

// File: rtl/fsk_tone_ctrl.sv
module fsk_tone_ctrl
    import fsk_mod_pkg::*;
#(
    parameter int CLK_HZ = 3579545,
    parameter int DIV    = 46,
    parameter int PW     = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_down_i,
    input  logic          squelch_i,
    input  logic          echo_req_i,
    input  logic          std_v21_i,
    input  logic          originate_i,
    input  logic          tx_bit_i,
    output fsk_state_e    state_o,
    output logic [PW-1:0] inc_o
);

    fsk_state_e state_q;
    fsk_state_e state_d;
    tone_e      tone_sel;
    logic       tone_on;

    logic [PW-1:0] tw_tab [NUM_TONES];

    // One tuning word per tone slot, derived from clock, divider and width.
    for (genvar g = 0; g < NUM_TONES; g++) begin : g_tw
        localparam longint WORD = tuning_word(tone_hz(g), CLK_HZ, DIV, PW);
        assign tw_tab[g] = WORD[PW-1:0];
    end

    // Next state: power-down, then squelch, then echo, then data.
    always_comb begin
        if (pwr_down_i)      state_d = ST_OFF;
        else if (squelch_i)  state_d = ST_MUTE;
        else if (echo_req_i) state_d = ST_ECHO;
        else                 state_d = ST_DATA;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Outputs of each state: which tone, and whether the phase may move.
    always_comb begin
        tone_sel = TN_B103_ORG_SPACE;
        tone_on  = 1'b0;
        unique case (state_q)
            ST_OFF, ST_MUTE: begin
                tone_on = 1'b0;
            end
            ST_ECHO: begin
                tone_on  = 1'b1;
                tone_sel = std_v21_i ? TN_V21_ECHO : TN_B103_ECHO;
            end
            ST_DATA: begin
                tone_on = 1'b1;
                unique case ({std_v21_i, originate_i, tx_bit_i})
                    3'b010:  tone_sel = TN_B103_ORG_SPACE;
                    3'b011:  tone_sel = TN_B103_ORG_MARK;
                    3'b000:  tone_sel = TN_B103_ANS_SPACE;
                    3'b001:  tone_sel = TN_B103_ANS_MARK;
                    3'b111:  tone_sel = TN_V21_CH1_MARK;
                    3'b110:  tone_sel = TN_V21_CH1_SPACE;
                    3'b101:  tone_sel = TN_V21_CH2_MARK;
                    default: tone_sel = TN_V21_CH2_SPACE;
                endcase
            end
            default: tone_on = 1'b0;
        endcase
    end

    assign inc_o   = tone_on ? tw_tab[tone_sel] : '0;
    assign state_o = state_q;

    AST_ECHO_OVER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down_i && !squelch_i && echo_req_i) |=> (state_q == ST_ECHO)); // R8
    AST_SQUELCH_OVER_ECHO: assert property (@(posedge clk) disable iff (!rst_n)
        (!pwr_down_i && squelch_i) |=> (state_q == ST_MUTE)); // R8

endmodule

// File: rtl/fsk_phase_acc.sv
module fsk_phase_acc #(
    parameter int DIV = 46,
    parameter int PW  = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic [PW-1:0] inc_i,
    output logic [PW-1:0] phase_o,
    output logic          tick_o
);

    localparam int CW = $clog2(DIV);
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;
    logic [PW-1:0] acc_q;
    logic          tick_q;

    always_ff @(posedge clk) begin
        if (!rst_n || clr_i) begin
            cnt_q  <= '0;
            acc_q  <= '0;
            tick_q <= 1'b0;
        end else begin
            tick_q <= 1'b0;
            if (cnt_q == LAST) begin
                cnt_q  <= '0;
                acc_q  <= acc_q + inc_i;
                tick_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign phase_o = acc_q;
    assign tick_o  = tick_q;

    AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (phase_o == '0 && !tick_o)); // R9
    AST_PHASE_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !$past(clr_i) && !tick_o) |-> $stable(phase_o)); // R7

endmodule

// File: rtl/fsk_sine_rom.sv
module fsk_sine_rom
    import fsk_mod_pkg::*;
#(
    parameter int AW = 6,
    parameter int OW = 10
) (
    input  logic [AW+1:0]        phase_i,
    output logic signed [OW-1:0] sample_o
);

    localparam int N   = 1 << AW;
    localparam int AMP = (1 << (OW - 1)) - 1;

    logic [OW-2:0] tab [N];

    for (genvar g = 0; g < N; g++) begin : g_tab
        localparam int VAL = qwave(g, N, AMP);
        localparam logic [OW-2:0] ENTRY = VAL[OW-2:0];
        assign tab[g] = ENTRY;
    end

    logic [1:0]         quad;
    logic [AW-1:0]      idx;
    logic [AW-1:0]      addr;
    logic signed [OW-1:0] mag;

    assign quad = phase_i[AW+1:AW];
    assign idx  = phase_i[AW-1:0];

    // Odd quadrants read the table backwards; the upper half is negated.
    always_comb begin
        addr     = quad[0] ? ~idx : idx;
        mag      = $signed({1'b0, tab[addr]});
        sample_o = quad[1] ? -mag : mag;
    end

endmodule

// File: rtl/fsk_tone_mod.sv
module fsk_tone_mod
    import fsk_mod_pkg::*;
#(
    parameter int CLK_HZ = 3579545,
    parameter int DIV    = 46,
    parameter int PW     = 24,
    parameter int AW     = 6,
    parameter int OW     = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pwr_down_i,
    input  logic                 squelch_i,
    input  logic                 echo_req_i,
    input  logic                 std_v21_i,
    input  logic                 originate_i,
    input  logic                 tx_bit_i,
    output logic signed [OW-1:0] sample_o,
    output logic                 sample_vld_o
);

    localparam int GW = $clog2(DIV) + 1;

    fsk_state_e           state;
    logic [PW-1:0]        inc;
    logic [PW-1:0]        phase;
    logic                 tick;
    logic signed [OW-1:0] sine;
    logic signed [OW-1:0] sample_q;
    logic                 vld_q;

    fsk_tone_ctrl #(.CLK_HZ(CLK_HZ), .DIV(DIV), .PW(PW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_down_i  (pwr_down_i),
        .squelch_i   (squelch_i),
        .echo_req_i  (echo_req_i),
        .std_v21_i   (std_v21_i),
        .originate_i (originate_i),
        .tx_bit_i    (tx_bit_i),
        .state_o     (state),
        .inc_o       (inc)
    );

    fsk_phase_acc #(.DIV(DIV), .PW(PW)) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (state == ST_OFF),
        .inc_i   (inc),
        .phase_o (phase),
        .tick_o  (tick)
    );

    fsk_sine_rom #(.AW(AW), .OW(OW)) u_rom (
        .phase_i  (phase[PW-1 -: AW+2]),
        .sample_o (sine)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_OFF) begin
            sample_q <= '0;
            vld_q    <= 1'b0;
        end else begin
            vld_q <= tick;
            if (tick) sample_q <= (state == ST_MUTE) ? '0 : sine;
        end
    end

    assign sample_o     = sample_q;
    assign sample_vld_o = vld_q;

    // Strobe spacing monitor.
    logic [GW-1:0] gap_q;
    logic          seen_q;
    always_ff @(posedge clk) begin
        if (!rst_n || state == ST_OFF) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (vld_q) begin
            gap_q  <= '0;
            seen_q <= 1'b1;
        end else if (gap_q != '1) begin
            gap_q <= gap_q + 1'b1;
        end
    end

    AST_STROBE_PERIOD: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_o && seen_q) |-> (gap_q == GW'(DIV - 1))); // R1
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        sample_vld_o |=> !sample_vld_o); // R1
    AST_SQUELCH_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_vld_o && $past(squelch_i, 2) && !$past(pwr_down_i, 2)) |-> (sample_o == '0)); // R7
    AST_PD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(pwr_down_i, 2) && $past(pwr_down_i)) |-> (!sample_vld_o && sample_o == '0)); // R9

endmodule

// File: tb/fsk_tone_mod_test.sv
`timescale 1ns/1ps
module fsk_tone_mod_test;

    localparam int  CLK_PERIOD = 280;
    localparam int  DIV        = 46;
    localparam real FCLK       = 3579545.0;
    localparam int  TOL        = 8;
    localparam int  NV         = 14;
    localparam int  NS         = 40;

    // {std_v21, originate, tx_bit, echo_req, squelch}
    localparam logic [4:0] VEC [NV] = '{
        5'b01000, 5'b01100, 5'b00000, 5'b00100,
        5'b11100, 5'b11000, 5'b10100, 5'b10000,
        5'b10110, 5'b11010, 5'b01110, 5'b01011,
        5'b11101, 5'b11100
    };
    localparam int VHZ [NV] = '{
        1070, 1270, 2025, 2225, 980, 1180, 1650, 1850,
        2100, 2100, 2225, 0, 0, 980
    };
    localparam string VTAG [NV] = '{
        "R2 Bell orig space", "R2 Bell orig mark", "R3 Bell ans space", "R3 Bell ans mark",
        "R4 V21 ch1 mark", "R4 V21 ch1 space", "R5 V21 ch2 mark", "R5 V21 ch2 space",
        "R6 V21 echo", "R6 V21 echo orig", "R6 Bell echo", "R8 squelch over echo",
        "R7 squelch", "R10 resume after squelch"
    };

    logic clk = 1'b0;
    logic rst_n;
    logic pwr_down, squelch, echo_req, std_v21, originate, tx_bit;
    logic signed [9:0] sample;
    logic sample_vld;

    int checks = 0;
    int errors = 0;
    logic [23:0] mph;
    int peak_hi = -1000;
    int peak_lo = 1000;

    always #(CLK_PERIOD / 2) clk = ~clk;

    fsk_tone_mod uut (
        .clk          (clk),
        .rst_n        (rst_n),
        .pwr_down_i   (pwr_down),
        .squelch_i    (squelch),
        .echo_req_i   (echo_req),
        .std_v21_i    (std_v21),
        .originate_i  (originate),
        .tx_bit_i     (tx_bit),
        .sample_o     (sample),
        .sample_vld_o (sample_vld)
    );

    function automatic int tw(int hz);
        return $rtoi(real'(hz) * 16777216.0 * real'(DIV) / FCLK + 0.5);
    endfunction

    function automatic int ideal(logic [23:0] ph);
        real r;
        r = 511.0 * $sin(2.0 * 3.14159265358979 * real'(ph) / 16777216.0);
        return (r >= 0.0) ? $rtoi(r + 0.5) : -$rtoi(-r + 0.5);
    endfunction

    task automatic apply(input logic [4:0] v);
        {std_v21, originate, tx_bit, echo_req, squelch} = v;
    endtask

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, expv);
        end
    endtask

    task automatic wait_vld(output bit ok);
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sample_vld && n < 500);
        ok = sample_vld;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        bit ok;
        int n;
        int worst;
        int d;
        int e;
        rst_n    = 1'b0;
        pwr_down = 1'b0;
        apply(VEC[0]);
        repeat (5) @(negedge clk);
        // R12: reset state
        check(sample == 0 && !sample_vld, "R12 reset outputs", int'(sample) + 1000 * int'(sample_vld), 0);
        rst_n = 1'b1;
        mph   = '0;

        // Vector walk: each row holds its inputs for NS strobes.
        for (int v = 0; v < NV; v++) begin
            apply(VEC[v]);
            worst = 0;
            for (int k = 0; k < NS; k++) begin
                wait_vld(ok);
                if (!ok) begin
                    worst = 9999;
                    break;
                end
                if (VHZ[v] == 0) e = 0;
                else begin
                    mph = mph + 24'(tw(VHZ[v]));
                    e   = ideal(mph);
                end
                d = int'(sample) - e;
                if (d < 0) d = -d;
                if (d > worst) worst = d;
                if (int'(sample) > peak_hi) peak_hi = int'(sample);
                if (int'(sample) < peak_lo) peak_lo = int'(sample);
            end
            check(worst <= ((VHZ[v] == 0) ? 0 : TOL), VTAG[v], worst, (VHZ[v] == 0) ? 0 : TOL);
        end

        // R11: amplitude and sign encoding
        check(peak_hi >= 505 && peak_hi <= 511, "R11 positive peak", peak_hi, 511);
        check(peak_lo <= -505 && peak_lo >= -511, "R11 negative peak", peak_lo, -511);

        // R1: spacing and pulse width
        wait_vld(ok);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!sample_vld && n < 500);
        check(n == DIV, "R1 strobe spacing", n, DIV);
        @(negedge clk);
        check(!sample_vld, "R1 strobe single cycle", int'(sample_vld), 0);

        // R9/R8: power-down together with squelch and echo
        wait_vld(ok);
        pwr_down = 1'b1;
        squelch  = 1'b1;
        echo_req = 1'b1;
        n = 0;
        for (int c = 0; c < 200; c++) begin
            @(negedge clk);
            if (sample_vld) n++;
        end
        check(n == 0, "R9 R8 no strobe in power-down", n, 0);
        check(sample == 0, "R9 sample zero in power-down", int'(sample), 0);

        // R9: phase restarts from zero after release
        pwr_down = 1'b0;
        apply(VEC[4]);
        mph = 24'(tw(980));
        wait_vld(ok);
        e = ideal(mph);
        d = int'(sample) - e;
        if (d < 0) d = -d;
        check(ok && d <= TOL, "R9 first sample after power-up", int'(sample), e);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule